// File: doc/BRIEF.md
# Single-Level Interrupt Injection Controller

This block adds one external interrupt to a small microcontroller whose core has no interrupt logic. It runs on a fast system clock and samples the processor's machine clock as an ordinary input. The processor presents each fetched instruction word after the falling edge of the machine clock. The word is valid only after a settling delay, so the block decodes it a fixed number of system-clock cycles after that edge. It then holds the decoded result until the next decode point, because the address and the word change before the next rising edge.

A request arrives in one of two modes. In edge mode, a rising edge of the request is latched until it is taken. In handshake mode, the request is a level, and the acknowledge stays high until the requester drops it. At each decode point the block checks whether it is safe to take a request. It is not safe while an EXECUTE instruction runs, because the address bus then differs from the program counter. It is also not safe while the inhibit input is high or while an earlier interrupt is still in service. When it takes a request, the block does the following for one machine cycle: it disables program memory, drives the fixed service address, enables the return-address register and pulses its capture strobe. A configurable RETURN pattern decoded during service drives the saved address back and ends the service.

Top module: `intinj_top`

## Requirements
- R1: A synchronous active-low reset clears the pending, in-service and acknowledge states. While reset is held and after it is released, promDisable, vectorAddr, saveEn, saveClk, retEn and irqAck are all 0.
- R2: The instruction word is sampled DECODE_DELAY (default 2) system-clock cycles after a falling edge of mclk is seen. The decoded result is held until the next decode point, so changes to instr outside that sample cycle have no effect.
- R3: In edge mode (modeEdge=1), a rising edge of irqReq sets a pending latch. The latch stays set while the request is blocked and is cleared when the interrupt is taken.
- R4: In handshake mode (modeEdge=0), a high irqReq is taken and irqAck goes high. irqAck stays high until irqReq is low, and no new interrupt is taken while irqAck is high.
- R5: An instruction whose top three bits (instr[15:13]) equal 3'b100 (EXECUTE) blocks taking an interrupt at that decode point.
- R6: A high irqInhibit at the decode point blocks taking an interrupt. In edge mode the request stays pending.
- R7: Taking an interrupt sets promDisable and saveEn and drives vectorAddr to octal 17777, from that decode point until the next one. At all other times vectorAddr is 0.
- R8: Each taken interrupt produces exactly one saveClk pulse, one system clock long.
- R9: During service, an instruction with (instr & 16'hFF00) == 16'hE700 (RETURN) sets retEn until the next decode point and ends the service. RETURN outside service has no effect.
- R10: No interrupt is taken while one is in service. An edge-mode request that arrives during service is taken after the RETURN.
- R11: In edge mode, irqAck is high exactly while promDisable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk | input | 1 | Processor machine clock, sampled |
| instr | input | 16 | Fetched instruction word |
| irqReq | input | 1 | Interrupt request |
| modeEdge | input | 1 | 1: edge mode, 0: handshake mode |
| irqInhibit | input | 1 | Blocks acceptance when high |
| promDisable | output | 1 | Disables program memory during the vector cycle |
| vectorAddr | output | 13 | Forced service address, 0 when idle |
| saveEn | output | 1 | Return-address register enable |
| saveClk | output | 1 | One-cycle capture strobe for the return address |
| retEn | output | 1 | Drives the saved return address back |
| irqAck | output | 1 | Interrupt acknowledge |

## Verification
The assertions assume that irqReq and irqInhibit are synchronous to clk. They also assume that the mode select changes only while reset is held. The stimulus meets both assumptions: the request and inhibit change only at the start of the high phase of mclk, well before the decode point, and the mode is set inside reset. The instruction word is valid from the falling edge of mclk through the sample window. After the window it is replaced with random data, which exercises the hold behaviour.

// File: rtl/intinj_pkg.sv
package intinj_pkg;
  localparam int OPCODE_W = 3;
  localparam logic [OPCODE_W-1:0] OP_EXECUTE = 3'b100;

  typedef struct packed {
    logic clearPend;
    logic forceVector;
    logic saveStrobe;
    logic driveReturn;
  } ctlStrobes_t;
endpackage

// File: rtl/intinj_datapath.sv
module intinj_datapath
  import intinj_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int ADDR_W = 13,
  parameter int DECODE_DELAY = 2,
  parameter logic [ADDR_W-1:0] VECTOR_ADDR = 13'o17777,
  parameter logic [INSTR_W-1:0] RET_MASK = 16'hFF00,
  parameter logic [INSTR_W-1:0] RET_MATCH = 16'hE700
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mclk,
  input  logic [INSTR_W-1:0] instr,
  input  logic               irqReq,
  input  logic               modeEdge,
  input  ctlStrobes_t        strobes,
  output logic               decodeValid,
  output logic               isExec,
  output logic               isRet,
  output logic               pending,
  output logic               promDisable,
  output logic [ADDR_W-1:0]  vectorAddr,
  output logic               saveEn,
  output logic               saveClk,
  output logic               retEn
);
  localparam int CNT_W = $clog2(DECODE_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DECODE_DELAY);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(1);

  logic             mclkQ;
  logic             mclkFall;
  logic [CNT_W-1:0] delayCnt;
  logic             sampleNow;
  logic             reqQ;
  logic             reqRise;
  logic             execQ;
  logic             retQ;
  logic             validQ;
  logic             pendQ;

  // Falling edge of the sampled machine clock starts the settle delay.
  assign mclkFall  = mclkQ & ~mclk;
  assign sampleNow = (delayCnt == CNT_FIRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mclkQ    <= 1'b0;
      delayCnt <= '0;
    end else begin
      mclkQ <= mclk;
      if (mclkFall)
        delayCnt <= CNT_LOAD;
      else if (delayCnt != '0)
        delayCnt <= delayCnt - CNT_FIRE;
    end
  end

  // Opcode latch: captured once per machine cycle, held until the next one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      execQ  <= 1'b0;
      retQ   <= 1'b0;
      validQ <= 1'b0;
    end else begin
      validQ <= sampleNow;
      if (sampleNow) begin
        execQ <= (instr[INSTR_W-1 -: OPCODE_W] == OP_EXECUTE);
        retQ  <= ((instr & RET_MASK) == RET_MATCH);
      end
    end
  end

  // Request capture for edge mode; a new edge wins over a clear.
  assign reqRise = irqReq & ~reqQ & modeEdge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqQ  <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      reqQ <= irqReq;
      if (reqRise)
        pendQ <= 1'b1;
      else if (strobes.clearPend)
        pendQ <= 1'b0;
    end
  end

  assign decodeValid = validQ;
  assign isExec      = execQ;
  assign isRet       = retQ;
  assign pending     = pendQ;

  // Output drivers for the instruction path and the return-address register.
  assign promDisable = strobes.forceVector;
  assign vectorAddr  = strobes.forceVector ? VECTOR_ADDR : '0;
  assign saveEn      = strobes.forceVector;
  assign saveClk     = strobes.saveStrobe;
  assign retEn       = strobes.driveReturn;
endmodule

// File: rtl/intinj_control.sv
module intinj_control
  import intinj_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        decodeValid,
  input  logic        isExec,
  input  logic        isRet,
  input  logic        pending,
  input  logic        irqReq,
  input  logic        modeEdge,
  input  logic        irqInhibit,
  output ctlStrobes_t strobes,
  output logic        irqAck
);
  logic forceQ;
  logic saveQ;
  logic returnQ;
  logic inServiceQ;
  logic hsAckQ;
  logic requestSeen;
  logic takeOk;

  assign requestSeen = modeEdge ? pending : (irqReq & ~hsAckQ);
  assign takeOk = decodeValid & ~inServiceQ & ~irqInhibit & ~isExec & requestSeen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      forceQ     <= 1'b0;
      saveQ      <= 1'b0;
      returnQ    <= 1'b0;
      inServiceQ <= 1'b0;
      hsAckQ     <= 1'b0;
    end else begin
      saveQ <= 1'b0;
      if (!irqReq)
        hsAckQ <= 1'b0;
      if (decodeValid) begin
        forceQ  <= 1'b0;
        returnQ <= 1'b0;
        if (inServiceQ && isRet) begin
          returnQ    <= 1'b1;
          inServiceQ <= 1'b0;
        end else if (takeOk) begin
          forceQ     <= 1'b1;
          saveQ      <= 1'b1;
          inServiceQ <= 1'b1;
          if (!modeEdge)
            hsAckQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.clearPend   = takeOk & modeEdge;
    strobes.forceVector = forceQ;
    strobes.saveStrobe  = saveQ;
    strobes.driveReturn = returnQ;
  end

  assign irqAck = modeEdge ? forceQ : hsAckQ;
endmodule

// File: rtl/intinj_top.sv
module intinj_top
  import intinj_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int ADDR_W = 13,
  parameter int DECODE_DELAY = 2,
  parameter logic [ADDR_W-1:0] VECTOR_ADDR = 13'o17777,
  parameter logic [INSTR_W-1:0] RET_MASK = 16'hFF00,
  parameter logic [INSTR_W-1:0] RET_MATCH = 16'hE700
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mclk,
  input  logic [INSTR_W-1:0] instr,
  input  logic               irqReq,
  input  logic               modeEdge,
  input  logic               irqInhibit,
  output logic               promDisable,
  output logic [ADDR_W-1:0]  vectorAddr,
  output logic               saveEn,
  output logic               saveClk,
  output logic               retEn,
  output logic               irqAck
);
  ctlStrobes_t strobes;
  logic decodeValid;
  logic isExec;
  logic isRet;
  logic pending;

  intinj_datapath #(
    .INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .DECODE_DELAY(DECODE_DELAY),
    .VECTOR_ADDR(VECTOR_ADDR), .RET_MASK(RET_MASK), .RET_MATCH(RET_MATCH)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .mclk(mclk), .instr(instr), .irqReq(irqReq),
    .modeEdge(modeEdge), .strobes(strobes), .decodeValid(decodeValid),
    .isExec(isExec), .isRet(isRet), .pending(pending),
    .promDisable(promDisable), .vectorAddr(vectorAddr), .saveEn(saveEn),
    .saveClk(saveClk), .retEn(retEn)
  );

  intinj_control u_control (
    .clk(clk), .rst_n(rst_n), .decodeValid(decodeValid), .isExec(isExec),
    .isRet(isRet), .pending(pending), .irqReq(irqReq), .modeEdge(modeEdge),
    .irqInhibit(irqInhibit), .strobes(strobes), .irqAck(irqAck)
  );
endmodule

// File: rtl/intinj_checker.sv
module intinj_checker (
  input logic clk,
  input logic rst_n,
  input logic irqReq,
  input logic modeEdge,
  input logic irqInhibit,
  input logic promDisable,
  input logic saveClk,
  input logic retEn,
  input logic irqAck
);
  assert_save_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    saveClk |=> !saveClk);

  assert_save_with_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    saveClk |-> promDisable);

  assert_inhibit_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (saveClk && $past(rst_n)) |-> !$past(irqInhibit));

  assert_ret_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(retEn && promDisable));

  assert_hs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeEdge && $past(rst_n) && $fell(irqAck)) |-> !$past(irqReq));
endmodule

bind intinj_top intinj_checker u_checker (
  .clk(clk), .rst_n(rst_n), .irqReq(irqReq), .modeEdge(modeEdge),
  .irqInhibit(irqInhibit), .promDisable(promDisable), .saveClk(saveClk),
  .retEn(retEn), .irqAck(irqAck)
);

// File: tb/test_intinj_top.sv
module test_intinj_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mclk = 1'b0;
  logic [15:0] instr = '0;
  logic        irqReq = 1'b0;
  logic        modeEdge = 1'b1;
  logic        irqInhibit = 1'b0;
  logic        promDisable;
  logic [12:0] vectorAddr;
  logic        saveEn;
  logic        saveClk;
  logic        retEn;
  logic        irqAck;

  int compared = 0;
  int mismatched = 0;
  int savePulses = 0;
  bit finished = 0;

  // model state
  bit mPend, mInSvc, mHsAck, mProm, mRet, mPrevReq;
  int mSaves = 0;

  localparam logic [15:0] NOP  = 16'h2000;
  localparam logic [15:0] EXEC = 16'h8123;
  localparam logic [15:0] RET  = 16'hE700;

  always #10 clk = ~clk;

  intinj_top i_intinj_top (
    .clk(clk), .rst_n(rst_n), .mclk(mclk), .instr(instr), .irqReq(irqReq),
    .modeEdge(modeEdge), .irqInhibit(irqInhibit), .promDisable(promDisable),
    .vectorAddr(vectorAddr), .saveEn(saveEn), .saveClk(saveClk),
    .retEn(retEn), .irqAck(irqAck)
  );

  always @(posedge clk) if (rst_n && saveClk) savePulses <= savePulses + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string scen);
    check("R7", {scen, " promDisable"}, int'(promDisable), int'(mProm));
    check("R7", {scen, " vectorAddr"}, int'(vectorAddr), mProm ? 8191 : 0);
    check("R7", {scen, " saveEn"}, int'(saveEn), int'(mProm));
    check("R9", {scen, " retEn"}, int'(retEn), int'(mRet));
    check(modeEdge ? "R11" : "R4", {scen, " irqAck"}, int'(irqAck),
          modeEdge ? int'(mProm) : int'(mHsAck));
    check("R8", {scen, " saveClk pulses"}, savePulses, mSaves);
  endtask

  task automatic doReset(input bit edgeMode);
    @(negedge clk);
    rst_n = 1'b0; mclk = 1'b0; irqReq = 1'b0; irqInhibit = 1'b0;
    modeEdge = edgeMode;
    repeat (3) @(negedge clk);
    // R1: outputs low while reset held
    check("R1", "reset promDisable", int'(promDisable), 0);
    check("R1", "reset irqAck", int'(irqAck), 0);
    check("R1", "reset saveClk", int'(saveClk), 0);
    rst_n = 1'b1;
    mPend = 0; mInSvc = 0; mHsAck = 0; mProm = 0; mRet = 0; mPrevReq = 0;
    @(negedge clk);
    check("R1", "after reset vectorAddr", int'(vectorAddr), 0);
    check("R1", "after reset retEn", int'(retEn), 0);
  endtask

  // One machine cycle: request/inhibit change in the high phase, the word is
  // valid from the falling edge through the sample window, then garbage (R2).
  task automatic machCycle(input logic [15:0] iw, input bit req, input bit inh,
                           input string scen);
    bit ex, rt;
    @(negedge clk);
    irqReq = req; irqInhibit = inh; mclk = 1'b1; instr = 16'($urandom);
    if (modeEdge && req && !mPrevReq) mPend = 1;
    if (!req) mHsAck = 0;
    mPrevReq = req;
    repeat (8) @(negedge clk);
    mclk = 1'b0; instr = iw;
    repeat (5) @(negedge clk);
    instr = 16'($urandom);
    repeat (3) @(negedge clk);
    ex = (iw[15:13] == 3'b100);
    rt = ((iw & 16'hFF00) == 16'hE700);
    mProm = 0; mRet = 0;
    if (mInSvc && rt) begin
      mRet = 1; mInSvc = 0;
    end else if (!mInSvc && !inh && !ex && (modeEdge ? mPend : (req && !mHsAck))) begin
      mProm = 1; mInSvc = 1; mSaves++;
      if (modeEdge) mPend = 0; else mHsAck = 1;
    end
    checkAll(scen);
  endtask

  function automatic logic [15:0] randInstr();
    int sel = int'($urandom_range(0, 99));
    if (sel < 15) return RET;
    if (sel < 30) return {3'b100, 13'($urandom)};
    return 16'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd4242));
    // Edge mode directed
    doReset(1'b1);
    machCycle(NOP, 1, 0, "R3 edge take");
    machCycle(NOP, 1, 0, "R7 vector ends");
    machCycle(RET, 0, 0, "R9 return");
    machCycle(RET, 0, 0, "R9 return outside service");
    machCycle(EXEC, 1, 0, "R5 execute blocks");
    machCycle(NOP, 1, 0, "R3 pending kept then taken");
    machCycle(RET, 0, 0, "R9 return");
    machCycle(NOP, 1, 1, "R6 inhibit blocks");
    machCycle(NOP, 1, 1, "R6 inhibit still");
    machCycle(NOP, 1, 0, "R6 taken after inhibit");
    machCycle(NOP, 0, 0, "R10 in service");
    machCycle(NOP, 1, 0, "R10 new edge not taken");
    machCycle(RET, 1, 0, "R10 return");
    machCycle(NOP, 1, 0, "R10 queued edge taken");
    machCycle(RET, 0, 0, "R9 return");
    machCycle(16'h8000 | RET, 1, 0, "R2 decoded word used");
    doReset(1'b1);
    for (int i = 0; i < 150; i++)
      machCycle(randInstr(), bit'($urandom_range(0, 1)),
                ($urandom_range(0, 4) == 0), "R3 random edge");
    // Handshake mode directed
    doReset(1'b0);
    machCycle(NOP, 1, 0, "R4 handshake take");
    machCycle(NOP, 1, 0, "R4 ack held");
    machCycle(RET, 1, 0, "R4 return with request high");
    machCycle(NOP, 1, 0, "R4 no retake while ack");
    machCycle(NOP, 0, 0, "R4 release");
    machCycle(EXEC, 1, 0, "R5 execute blocks handshake");
    machCycle(NOP, 1, 0, "R4 take again");
    doReset(1'b0);
    for (int i = 0; i < 150; i++)
      machCycle(randInstr(), bit'($urandom_range(0, 1)),
                ($urandom_range(0, 4) == 0), "R4 random handshake");
    // R1: reset mid-service
    machCycle(NOP, 0, 0, "R4 drop");
    machCycle(NOP, 1, 0, "R4 take before reset");
    doReset(1'b1);
    machCycle(NOP, 0, 0, "R1 idle after reset");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule